// File: doc/BRIEF.md
# SRAM Retention-Mode Power Sequencer

This block places an external asynchronous static RAM into its low-power retention state and brings it back out, on request from a host. The memory has a dedicated retention select line. Driving that line low turns off the memory's internal supply but keeps the cell array powered. Driving it high returns the part to ordinary standby. The memory must be deselected before the retention line falls. After the line rises again, the memory needs a long recovery window before the next access, and the deselect lines must stay inactive for that whole window.

The sequencer has four states: active, deselect, retention and recover. It moves through them with a single down-counter, and every delay is a parameter counted in system clock cycles. A build-time parameter picks which lines keep the memory deselected:

- **Chip-select scheme:** chip select is held high.
- **Byte-select scheme:** both byte selects are held high.

While the sequencer is active, it passes the access controller's chip select and byte selects straight through to the memory. In every other state it raises a stall toward that controller. While the memory is in retention it also raises a float indication, which tells neighbouring logic that address, data and strobe lines may be released.

Top module: `sram_retention_seq`

## Requirements
- R1: During and right after reset the block is active: retention select is high, ready is 1, stall is 0, float is 0, and the memory selects follow the access inputs.
- R2: While active, `mem_cs_n_o` equals `acc_cs_n_i` and `mem_bsel_n_o` equals `acc_bsel_n_i` in the same cycle, for every input combination.
- R3: A sleep request sampled while active starts the deselect phase. The memory is deselected and retention select stays high for exactly max(DESEL_CYC,1) cycles. After that, retention select goes low.
- R4: In retention, retention select is 0, float is 1, and the deselect lines remain inactive.
- R5: A wake request in retention raises retention select and holds the deselect lines inactive for exactly max(RECOV_CYC,1) cycles. Only then does ready return.
- R6: Ready is 1 only in the active state, and stall is always the inverse of ready.
- R7: A wake request sampled during the deselect phase is remembered. Retention then lasts exactly one cycle before recovery starts.
- R8: A wake request while active, and a sleep request in retention, have no effect.
- R9: The deselected encoding depends on BYTE_SCHEME. With BYTE_SCHEME=0, chip select = 1 and byte selects = 00. With BYTE_SCHEME=1, chip select = 0 and byte selects = 11. Byte-select bit 0 is the low byte and bit 1 is the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to enter retention (sampled while active) |
| wake_req_i | input | 1 | Request to leave retention |
| acc_cs_n_i | input | 1 | Chip select from the access controller |
| acc_bsel_n_i | input | 2 | Byte selects from the access controller (bit 1 high byte) |
| ret_sel_o | output | 1 | Retention select to memory; low = retention |
| mem_cs_n_o | output | 1 | Chip select to memory, active low |
| mem_bsel_n_o | output | 2 | Byte selects to memory, active low |
| float_o | output | 1 | Memory bus lines may be released |
| ready_o | output | 1 | Memory may be accessed |
| stall_o | output | 1 | Hold off new accesses |

## Verification
The bench builds two instances side by side from the same stimulus:

- The first uses the chip-select scheme with DESEL_CYC=3 and RECOV_CYC=5, so the multi-cycle phases and a remembered wake request can be observed cycle by cycle.
- The second uses the byte-select scheme with DESEL_CYC=0 and RECOV_CYC=1, so the minimum one-cycle phases and the zero-delay clamp are reached.

Short recovery values keep every phase length small enough to count. The eight access input patterns are swept exhaustively in the active state.

// File: rtl/sret_pkg.sv
`timescale 1ns/1ps
package sret_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_DESEL  = 2'd1,
    ST_RET    = 2'd2,
    ST_RECOV  = 2'd3
  } sret_state_e;

  // A phase always lasts at least one cycle.
  function automatic int unsigned span_cyc(input int unsigned req);
    return (req < 1) ? 1 : req;
  endfunction

  // Counter width able to hold the larger phase length minus one.
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m) + 1;
  endfunction
endpackage

// File: rtl/sret_timer.sv
`timescale 1ns/1ps
module sret_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sret_fsm.sv
`timescale 1ns/1ps
module sret_fsm
  import sret_pkg::*;
#(
  parameter int unsigned   CW       = 4,
  parameter logic [CW-1:0] DESEL_LD = '0,
  parameter logic [CW-1:0] RECOV_LD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          tmr_done,
  output sret_state_e   state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          wake_pend,
  output logic          ev_enter_ret,
  output logic          ev_leave_ret
);
  sret_state_e state_nxt;
  logic        pend_nxt;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = DESEL_LD;
    unique case (state)
      ST_ACTIVE: if (sleep_req) begin
        state_nxt = ST_DESEL;
        tmr_load  = 1'b1;
        tmr_val   = DESEL_LD;
      end
      ST_DESEL:  if (tmr_done) state_nxt = ST_RET;
      ST_RET:    if (wake_req || wake_pend) begin
        state_nxt = ST_RECOV;
        tmr_load  = 1'b1;
        tmr_val   = RECOV_LD;
      end
      ST_RECOV:  if (tmr_done) state_nxt = ST_ACTIVE;
      default:   state_nxt = ST_ACTIVE;
    endcase
  end

  // Wake requests seen during deselect are kept until retention is reached.
  assign pend_nxt     = (state == ST_DESEL) ? (wake_pend | wake_req) : 1'b0;
  assign ev_enter_ret = (state == ST_DESEL) && (state_nxt == ST_RET);
  assign ev_leave_ret = (state == ST_RET)   && (state_nxt == ST_RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ACTIVE;
      wake_pend <= 1'b0;
    end else begin
      state     <= state_nxt;
      wake_pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/sret_pins.sv
`timescale 1ns/1ps
module sret_pins
  import sret_pkg::*;
#(
  parameter bit BYTE_SCHEME = 1'b0
) (
  input  sret_state_e state,
  input  logic        acc_cs_n,
  input  logic [1:0]  acc_bsel_n,
  output logic        ret_sel,
  output logic        cs_n,
  output logic [1:0]  bsel_n,
  output logic        float_en,
  output logic        ready,
  output logic        stall
);
  logic       quiet_cs_n;
  logic [1:0] quiet_bsel_n;

  generate
    if (BYTE_SCHEME) begin : g_byte
      assign quiet_cs_n   = 1'b0;
      assign quiet_bsel_n = 2'b11;
    end else begin : g_chip
      assign quiet_cs_n   = 1'b1;
      assign quiet_bsel_n = 2'b00;
    end
  endgenerate

  always_comb begin
    ready    = (state == ST_ACTIVE);
    stall    = !ready;
    ret_sel  = (state != ST_RET);
    float_en = (state == ST_RET);
    cs_n     = ready ? acc_cs_n   : quiet_cs_n;
    bsel_n   = ready ? acc_bsel_n : quiet_bsel_n;
  end
endmodule

// File: rtl/sram_retention_seq.sv
`timescale 1ns/1ps
module sram_retention_seq
  import sret_pkg::*;
#(
  parameter bit          BYTE_SCHEME = 1'b0,
  parameter int unsigned DESEL_CYC   = 4,
  parameter int unsigned RECOV_CYC   = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       acc_cs_n_i,
  input  logic [1:0] acc_bsel_n_i,
  output logic       ret_sel_o,
  output logic       mem_cs_n_o,
  output logic [1:0] mem_bsel_n_o,
  output logic       float_o,
  output logic       ready_o,
  output logic       stall_o
);
  localparam int unsigned   DSPAN    = span_cyc(DESEL_CYC);
  localparam int unsigned   RSPAN    = span_cyc(RECOV_CYC);
  localparam int unsigned   CW       = cnt_bits(DSPAN, RSPAN);
  localparam logic [CW-1:0] DESEL_LD = CW'(DSPAN - 1);
  localparam logic [CW-1:0] RECOV_LD = CW'(RSPAN - 1);

  sret_state_e   st;
  logic          tmr_load, tmr_done, wake_pend;
  logic          ev_enter_ret, ev_leave_ret;
  logic [CW-1:0] tmr_val;

  sret_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sret_fsm #(.CW(CW), .DESEL_LD(DESEL_LD), .RECOV_LD(RECOV_LD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req_i), .wake_req(wake_req_i),
    .tmr_done(tmr_done), .state(st), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .wake_pend(wake_pend), .ev_enter_ret(ev_enter_ret), .ev_leave_ret(ev_leave_ret)
  );

  sret_pins #(.BYTE_SCHEME(BYTE_SCHEME)) u_pins (
    .state(st), .acc_cs_n(acc_cs_n_i), .acc_bsel_n(acc_bsel_n_i),
    .ret_sel(ret_sel_o), .cs_n(mem_cs_n_o), .bsel_n(mem_bsel_n_o),
    .float_en(float_o), .ready(ready_o), .stall(stall_o)
  );
endmodule

// File: rtl/sret_chk.sv
`timescale 1ns/1ps
module sret_chk
  import sret_pkg::*;
#(
  parameter bit          BYTE_SCHEME = 1'b0,
  parameter int unsigned RECOV_SPAN  = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ret_sel_o,
  input logic        mem_cs_n_o,
  input logic [1:0]  mem_bsel_n_o,
  input logic        float_o,
  input logic        ready_o,
  input logic        stall_o,
  input sret_state_e state,
  input logic        wake_pend,
  input logic        ev_enter_ret,
  input logic        ev_leave_ret
);
  logic        quiet;
  logic [31:0] since_hi;

  assign quiet = BYTE_SCHEME ? (mem_bsel_n_o == 2'b11) : mem_cs_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_hi <= '0;
    else if (!ret_sel_o)        since_hi <= '0;
    else if (since_hi != '1)    since_hi <= since_hi + 1'b1;
  end

  a_r6_ready_vs_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o != stall_o);
  a_r6_ready_needs_awake: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ret_sel_o && !float_o));
  a_r3_deselect_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_sel_o) |-> (quiet && $past(quiet)));
  a_r4_float_in_ret: assert property (@(posedge clk) disable iff (!rst_n)
    float_o |-> (!ret_sel_o && quiet));
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_sel_o && stall_o) |-> quiet);
  a_r5_recovery_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (since_hi >= RECOV_SPAN));
  a_r7_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RET && wake_pend) |=> (state == ST_RECOV));
  a_r3_enter_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter_ret |=> !ret_sel_o);
  a_r5_leave_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leave_ret |=> (ret_sel_o && stall_o));
endmodule

bind sram_retention_seq sret_chk #(.BYTE_SCHEME(BYTE_SCHEME), .RECOV_SPAN(RSPAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_sel_o(ret_sel_o), .mem_cs_n_o(mem_cs_n_o),
  .mem_bsel_n_o(mem_bsel_n_o), .float_o(float_o), .ready_o(ready_o),
  .stall_o(stall_o), .state(st), .wake_pend(wake_pend),
  .ev_enter_ret(ev_enter_ret), .ev_leave_ret(ev_leave_ret)
);

// File: tb/sram_retention_seq_tb_top.sv
`timescale 1ns/1ps
// Cycle-level expectation built from the requirements: phase + elapsed ticks.
module sret_ref #(
  parameter bit BYTE = 1'b0,
  parameter int D    = 1,
  parameter int R    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep,
  input  logic       wake,
  input  logic       acc_cs_n,
  input  logic [1:0] acc_bsel,
  output logic [6:0] exp_o,
  output int         phase
);
  localparam int DM = (D < 1) ? 1 : D;
  localparam int RM = (R < 1) ? 1 : R;
  int ticks;
  bit held;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 0; ticks <= 0; held <= 0;
    end else begin
      case (phase)
        0: if (sleep) begin phase <= 1; ticks <= 1; held <= 0; end
        1: begin
             if (wake) held <= 1;
             if (ticks >= DM) phase <= 2; else ticks <= ticks + 1;
           end
        2: if (wake || held) begin phase <= 3; ticks <= 1; held <= 0; end
        default: if (ticks >= RM) phase <= 0; else ticks <= ticks + 1;
      endcase
    end
  end

  // {ret_sel, cs_n, bsel[1:0], float, ready, stall}
  always_comb begin
    if (phase == 0) exp_o = {1'b1, acc_cs_n, acc_bsel, 1'b0, 1'b1, 1'b0};
    else            exp_o = {phase != 2, !BYTE, BYTE ? 2'b11 : 2'b00, phase == 2, 1'b0, 1'b1};
  end
endmodule

module sram_retention_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, acc_cs_n = 1'b1;
  logic [1:0] acc_bsel = 2'b11;

  logic       ret_a, cs_a, flt_a, rdy_a, stl_a;
  logic [1:0] bs_a;
  logic       ret_b, cs_b, flt_b, rdy_b, stl_b;
  logic [1:0] bs_b;
  logic [6:0] exp_a, exp_b;
  int         ph_a, ph_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_retention_seq #(.BYTE_SCHEME(1'b0), .DESEL_CYC(3), .RECOV_CYC(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .acc_cs_n_i(acc_cs_n), .acc_bsel_n_i(acc_bsel), .ret_sel_o(ret_a),
    .mem_cs_n_o(cs_a), .mem_bsel_n_o(bs_a), .float_o(flt_a), .ready_o(rdy_a), .stall_o(stl_a)
  );
  sram_retention_seq #(.BYTE_SCHEME(1'b1), .DESEL_CYC(0), .RECOV_CYC(1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .acc_cs_n_i(acc_cs_n), .acc_bsel_n_i(acc_bsel), .ret_sel_o(ret_b),
    .mem_cs_n_o(cs_b), .mem_bsel_n_o(bs_b), .float_o(flt_b), .ready_o(rdy_b), .stall_o(stl_b)
  );

  sret_ref #(.BYTE(1'b0), .D(3), .R(5)) ref_a (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_req), .wake(wake_req),
    .acc_cs_n(acc_cs_n), .acc_bsel(acc_bsel), .exp_o(exp_a), .phase(ph_a));
  sret_ref #(.BYTE(1'b1), .D(0), .R(1)) ref_b (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_req), .wake(wake_req),
    .acc_cs_n(acc_cs_n), .acc_bsel(acc_bsel), .exp_o(exp_b), .phase(ph_b));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic string ph_tag(input int ph, input bit bdut);
    if (ph == 0) return "R2";
    if (bdut)    return "R9";
    if (ph == 1) return "R3";
    if (ph == 2) return "R4";
    return "R5";
  endfunction

  // Continuous comparison against the requirement model, away from the clock edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({ret_a, cs_a, bs_a, flt_a, rdy_a, stl_a} == exp_a, ph_tag(ph_a, 0), "dut_i pins",
          {ret_a, cs_a, bs_a, flt_a, rdy_a, stl_a}, exp_a);
      chk({ret_b, cs_b, bs_b, flt_b, rdy_b, stl_b} == exp_b, ph_tag(ph_b, 1), "dut_b_i pins",
          {ret_b, cs_b, bs_b, flt_b, rdy_b, stl_b}, exp_b);
    end
  end

  task automatic sample();
    @(negedge clk);
    sleep_req = 1'b0;
    wake_req  = 1'b0;
    #1;
  endtask

  // mode 0: deselect cycles until retention; 1: recovery cycles until ready;
  // 2: retention-low cycles until ready
  task automatic measure(input int mode, output int ca, output int cb);
    bit fa, fb;
    ca = 0; cb = 0; fa = 0; fb = 0;
    for (int i = 0; i < 40 && !(fa && fb); i++) begin
      sample();
      if (!fa) begin
        if ((mode == 0) ? !ret_a : rdy_a) fa = 1;
        else if ((mode == 2) ? !ret_a : (stl_a && ret_a)) ca++;
      end
      if (!fb) begin
        if ((mode == 0) ? !ret_b : rdy_b) fb = 1;
        else if ((mode == 2) ? !ret_b : (stl_b && ret_b)) cb++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ca, cb;
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    acc_cs_n = 1'b0; acc_bsel = 2'b10;
    #1;
    chk(ret_a && rdy_a && !stl_a && !flt_a && cs_a == 1'b0 && bs_a == 2'b10, "R1", "dut_i reset",
        {ret_a, rdy_a, stl_a, flt_a, cs_a, bs_a}, 7'b1100010);
    chk(ret_b && rdy_b && !stl_b && !flt_b && cs_b == 1'b0 && bs_b == 2'b10, "R1", "dut_b_i reset",
        {ret_b, rdy_b, stl_b, flt_b, cs_b, bs_b}, 7'b1100010);
    @(negedge clk); rst_n = 1'b1;
    sample();
    chk(rdy_a && rdy_b && ret_a && ret_b, "R1", "ready after reset", {rdy_a, rdy_b, ret_a, ret_b}, 4'hf);

    // R2: exhaustive pass-through sweep
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      acc_cs_n = p[2]; acc_bsel = p[1:0];
      #1;
      chk(cs_a == p[2] && bs_a == p[1:0], "R2", "dut_i pass-through", {cs_a, bs_a}, p);
      chk(cs_b == p[2] && bs_b == p[1:0], "R2", "dut_b_i pass-through", {cs_b, bs_b}, p);
    end

    // R8: wake while active has no effect
    @(negedge clk); wake_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sample();
      chk(rdy_a && rdy_b && ret_a && ret_b, "R8", "wake while active", {rdy_a, rdy_b}, 2'b11);
    end

    // R3: deselect length
    @(negedge clk); sleep_req = 1'b1;
    measure(0, ca, cb);
    chk(ca == 3, "R3", "dut_i deselect cycles", ca, 3);
    chk(cb == 1, "R3", "dut_b_i deselect cycles", cb, 1);

    // R4 and R9: retention encoding
    sample();
    chk(!ret_a && flt_a && cs_a == 1'b1 && bs_a == 2'b00, "R4", "dut_i retention",
        {ret_a, flt_a, cs_a, bs_a}, 5'b01100);
    chk(!ret_b && flt_b && cs_b == 1'b0 && bs_b == 2'b11, "R9", "dut_b_i retention",
        {ret_b, flt_b, cs_b, bs_b}, 5'b01011);
    chk(stl_a != rdy_a && stl_b != rdy_b && !rdy_a && !rdy_b, "R6", "stall in retention",
        {stl_a, rdy_a, stl_b, rdy_b}, 4'b1010);

    // R8: sleep in retention ignored
    @(negedge clk); sleep_req = 1'b1;
    repeat (2) sample();
    chk(!ret_a && !ret_b, "R8", "sleep in retention", {ret_a, ret_b}, 0);

    // R5: recovery length
    @(negedge clk); wake_req = 1'b1;
    measure(1, ca, cb);
    chk(ca == 5, "R5", "dut_i recovery cycles", ca, 5);
    chk(cb == 1, "R5", "dut_b_i recovery cycles", cb, 1);
    chk(rdy_a && !stl_a && rdy_b && !stl_b, "R6", "ready after recovery", {rdy_a, stl_a, rdy_b, stl_b}, 4'b1010);

    // R7: wake during deselect is held, retention lasts one cycle
    repeat (2) sample();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0; wake_req = 1'b1;
    measure(2, ca, cb);
    chk(ca == 1, "R7", "dut_i held wake retention cycles", ca, 1);
    chk(cb == 1, "R7", "dut_b_i held wake retention cycles", cb, 1);

    // Second full cycle with a different access pattern
    @(negedge clk); acc_cs_n = 1'b1; acc_bsel = 2'b01; sleep_req = 1'b1;
    measure(0, ca, cb);
    chk(ca == 3 && cb == 1, "R3", "repeat deselect", {ca[3:0], cb[3:0]}, 8'h31);
    repeat (5) sample();
    @(negedge clk); wake_req = 1'b1;
    measure(1, ca, cb);
    chk(ca == 5 && cb == 1, "R5", "repeat recovery", {ca[3:0], cb[3:0]}, 8'h51);
    repeat (3) sample();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule